// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a three-channel interval timer with a byte-wide register interface. Three data addresses each reach one channel's 16-bit counter, one control address takes command bytes, and one auxiliary address reports the level of channel 2's output. Each channel counts down by one on every cycle where `tick_en` is high. Channel 0's expiry drives an interrupt request.

A channel is set up in three writes: a control byte that picks the mode, then the low byte of the reload value, then the high byte. Software reads a count by first freezing it into the channel's output latch, either with a counter-latch command or with a read-back command. It then fetches the two bytes from the data address. A read-back command can also arm a one-shot status byte that reports the channel's mode. Two counting behaviours are implemented: a one-shot that holds its output high after terminal count, and a free-running square wave. Any other mode code is accepted and reported in the status byte, but the channel counts as a one-shot.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every channel holds reload 0xFFFF and count 0xFFFF, mode 0, a low output, no armed status, and a read pointer at the low byte. `irq` is low and `rdata` is 0.
- R2: A write to the control address (3) uses bits 7:6 to select a channel (0 to 2); the value 3 in that field marks a read-back command. Bits 5:4 give the access code. Access 00 copies the selected channel's current count into its output latch, leaves the mode unchanged and points the next data read at the low byte.
- R3: A control write with a nonzero access code stores bits 3:1 as the channel's mode and makes the next data write to that channel a low byte, discarding any pending low byte.
- R4: Data writes to address 0, 1 or 2 come in pairs, low byte first. The high-byte write loads the reload value and restarts the count from it. A reload of zero becomes 0xFFFF.
- R5: Data reads return the output latch, alternating between low and high byte, starting with the low byte after a latch. The latched value holds while the counter keeps running.
- R6: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2. When bit 5 is clear, each selected channel's count is latched and its read pointer goes to the low byte. When bit 4 is clear, each selected channel's status is armed.
- R7: A data read from a channel with armed status returns {2'b00, 2'b11, mode, 1'b0}. That read clears the armed flag and does not move the low/high pointer.
- R8: In mode 0, the count falls by one per tick until it reaches 0, then stays at 0. The output goes high when the count reaches 0 and stays high until the next high-byte write.
- R9: In mode 3, a tick at count 1 reloads the count instead of reaching 0. The output is high while the count is greater than half the reload value (rounded down).
- R10: Mode codes other than 3 are stored and reported by the status byte, and the channel counts as in mode 0.
- R11: `irq` is high for one cycle, in the cycle after a tick that finds channel 0's count at 1, in either mode.
- R12: A read of the auxiliary address (4) returns channel 2's output in bit 5 when that channel is in mode 0, and in bit 0 when it is in mode 3. All other bits, and all bits in other modes, are 0. Writes to address 4 have no effect.
- R13: Reads of the control address and of addresses 5 to 7 return 0. `rdata` changes only on the cycle after a read strobe.
- R14: When a high-byte write and a tick that would expire the count fall in the same cycle, the load wins and no expiry or interrupt occurs. When a latch command and a tick share a cycle, the latch captures the count from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable; each high cycle is one counter tick |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 3 | 0-2 channel data, 3 control, 4 auxiliary status |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Channel 0 expiry pulse |

## Verification
The two functions that can land on the same clock edge are a channel's own counting (a tick that expires or decrements the count) and a host command on that channel (the high-byte load or a counter-latch command). The bench provokes both overlaps by raising `tick_en` in the very cycle that carries the write strobe. It then judges the outcome at the ports. After a load collides with what would have been an expiry, `irq` must stay low and a fresh latch must read back the new reload value untouched. After a latch collides with a tick, the first read must show the pre-tick count and a second latch must show it one lower.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

   typedef logic [2:0] tmode_t;

   localparam tmode_t MODE_ONESHOT = 3'd0;
   localparam tmode_t MODE_SQUARE  = 3'd3;

   localparam logic [1:0] ACC_LATCH = 2'b00;
   localparam logic [1:0] ACC_WORD  = 2'b11;
   localparam logic [1:0] SEL_RDBK  = 2'b11;

   // readback control byte fields
   localparam int RB_NOCNT_BIT  = 5;
   localparam int RB_NOSTAT_BIT = 4;
   localparam int RB_CH_LSB     = 1;

   // auxiliary port bit positions
   localparam int AUX_TC_BIT  = 5;
   localparam int AUX_SQW_BIT = 0;

   function automatic logic [7:0] status_byte(input tmode_t m);
      return {2'b00, ACC_WORD, m, 1'b0};
   endfunction

endpackage

// File: rtl/tri_timer_channel.sv
module tri_timer_channel
   import tri_timer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              mode_wr,
   input  tmode_t            mode_in,
   input  logic              latch_cmd,
   input  logic              arm_cmd,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_val,
   output logic              out_lvl,
   output tmode_t            mode_q,
   output logic              expire
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0]  reload_q, count_q, olatch_q;
   logic [CNT_W-1:0]  count_nxt, new_val, load_val;
   logic [DATA_W-1:0] low_q;
   logic              wr_hi_q, rd_hi_q, armed_q, shot_q;
   logic              load, sqw, sq_high;

   assign load     = dat_wr && wr_hi_q;
   assign new_val  = {wdata, low_q};
   assign load_val = (new_val == '0) ? CNT_MAX : new_val;
   assign sqw      = (mode_q == MODE_SQUARE);
   assign expire   = tick_en && !load && (count_q == CNT_ONE);
   assign sq_high  = count_q > (reload_q >> 1);
   assign out_lvl  = sqw ? sq_high : shot_q;

   always_comb begin
      count_nxt = count_q;
      if (load)
         count_nxt = load_val;
      else if (tick_en) begin
         if (sqw)
            count_nxt = (count_q <= CNT_ONE) ? reload_q : count_q - CNT_ONE;
         else if (count_q != '0)
            count_nxt = count_q - CNT_ONE;
      end
   end

   always_comb begin
      if (armed_q)
         rd_val = status_byte(mode_q);
      else if (rd_hi_q)
         rd_val = olatch_q[CNT_W-1:DATA_W];
      else
         rd_val = olatch_q[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= CNT_MAX;
         count_q  <= CNT_MAX;
         olatch_q <= '0;
         low_q    <= '0;
         mode_q   <= MODE_ONESHOT;
         wr_hi_q  <= 1'b0;
         rd_hi_q  <= 1'b0;
         armed_q  <= 1'b0;
         shot_q   <= 1'b0;
      end else begin
         count_q <= count_nxt;
         if (load) begin
            reload_q <= load_val;
            shot_q   <= 1'b0;
         end else if (expire && !sqw) begin
            shot_q <= 1'b1;
         end
         if (mode_wr) begin
            mode_q  <= mode_in;
            wr_hi_q <= 1'b0;
         end
         if (dat_wr) begin
            if (!wr_hi_q) low_q <= wdata;
            wr_hi_q <= !wr_hi_q;
         end
         if (latch_cmd) begin
            olatch_q <= count_q;
            rd_hi_q  <= 1'b0;
         end
         if (arm_cmd) armed_q <= 1'b1;
         if (dat_rd) begin
            if (armed_q) armed_q <= 1'b0;
            else         rd_hi_q <= !rd_hi_q;
         end
      end
   end

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
   import tri_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 8,
   parameter int NUM_CH  = 3,
   parameter int ADDR_W  = 3,
   parameter int AUX_CH  = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] ADDR_AUX  = ADDR_W'(NUM_CH + 1);

   if (DATA_W != 8) begin : g_bad_dw
      $error("tri_interval_timer: DATA_W must be 8");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cw
      $error("tri_interval_timer: CNT_W must be twice DATA_W");
   end
   if (NUM_CH != 3) begin : g_bad_nc
      $error("tri_interval_timer: command format fixes NUM_CH at 3");
   end
   if (AUX_CH >= NUM_CH) begin : g_bad_aux
      $error("tri_interval_timer: AUX_CH out of range");
   end

   logic              ctl_wr, is_rb;
   logic [1:0]        sel, access;
   logic [DATA_W-1:0] ch_rd [NUM_CH];
   tmode_t            ch_mode [NUM_CH];
   logic [NUM_CH-1:0] ch_out, ch_exp;
   logic [DATA_W-1:0] aux_byte, rd_sel;

   assign ctl_wr = wr_en && (addr == ADDR_CTRL);
   assign sel    = wdata[7:6];
   assign access = wdata[5:4];
   assign is_rb  = (sel == SEL_RDBK);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_me, mode_wr, latch_cmd, arm_cmd, rb_me;

      assign sel_me    = ctl_wr && !is_rb && (sel == 2'(i));
      assign rb_me     = ctl_wr && is_rb && wdata[RB_CH_LSB + i];
      assign mode_wr   = sel_me && (access != ACC_LATCH);
      assign latch_cmd = (sel_me && (access == ACC_LATCH)) ||
                         (rb_me && !wdata[RB_NOCNT_BIT]);
      assign arm_cmd   = rb_me && !wdata[RB_NOSTAT_BIT];

      tri_timer_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_en   (tick_en),
         .mode_wr   (mode_wr),
         .mode_in   (wdata[3:1]),
         .latch_cmd (latch_cmd),
         .arm_cmd   (arm_cmd),
         .dat_wr    (wr_en && (addr == ADDR_W'(i))),
         .dat_rd    (rd_en && (addr == ADDR_W'(i))),
         .wdata     (wdata),
         .rd_val    (ch_rd[i]),
         .out_lvl   (ch_out[i]),
         .mode_q    (ch_mode[i]),
         .expire    (ch_exp[i])
      );
   end

   always_comb begin
      aux_byte = '0;
      if (ch_mode[AUX_CH] == MODE_ONESHOT)
         aux_byte[AUX_TC_BIT] = ch_out[AUX_CH];
      else if (ch_mode[AUX_CH] == MODE_SQUARE)
         aux_byte[AUX_SQW_BIT] = ch_out[AUX_CH];
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (addr == ADDR_W'(i)) rd_sel = ch_rd[i];
      if (addr == ADDR_AUX) rd_sel = aux_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_sel;
   end

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= ch_exp[0];
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = ch_exp[0];
   end

endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 3,
   parameter int NUM_CH  = 3,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              irq
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(NUM_CH + 1);
   localparam logic [DATA_W-1:0] AUX_UNUSED = ~DATA_W'(8'h21);

   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   p_ctrl_read_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_CTRL) |=> (rdata == '0));

   p_aux_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_AUX) |=> ((rdata & AUX_UNUSED) == '0));

   p_aux_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_AUX) |=> $onehot0(rdata));

   if (IRQ_REG) begin : g_irq_reg
      p_irq_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(tick_en));
   end else begin : g_irq_comb
      p_irq_with_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> tick_en);
   end

endmodule

bind tri_interval_timer tri_interval_timer_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .NUM_CH (NUM_CH),
   .IRQ_REG(IRQ_REG)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick_en(tick_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .rdata  (rdata),
   .irq    (irq)
);

// File: tb/tri_interval_timer_bench.sv
module tri_interval_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 64;
   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

   tri_interval_timer u_tri_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   // {kind, addr, data, expected, requirement number}
   localparam logic [24:0] VEC [NVEC] = '{
      {K_WR,3'd3,8'hEE,8'h00,4'd6},   // arm status on all channels
      {K_RD,3'd0,8'h00,8'h30,4'd1},   // R1 mode 0 after reset
      {K_RD,3'd1,8'h00,8'h30,4'd1},
      {K_RD,3'd2,8'h00,8'h30,4'd1},
      {K_WR,3'd3,8'h00,8'h00,4'd2},   // latch ch0
      {K_RD,3'd0,8'h00,8'hFF,4'd2},   // R2 low byte of 0xFFFF
      {K_WR,3'd3,8'h70,8'h00,4'd3},   // ch1 mode 0
      {K_WR,3'd1,8'h05,8'h00,4'd4},
      {K_WR,3'd1,8'h00,8'h00,4'd4},
      {K_WR,3'd3,8'h40,8'h00,4'd2},
      {K_RD,3'd1,8'h00,8'h05,4'd4},   // R4 loaded reload
      {K_TK,3'd0,8'd2 ,8'h00,4'd8},
      {K_WR,3'd3,8'h40,8'h00,4'd2},
      {K_RD,3'd1,8'h00,8'h03,4'd8},   // R8 decrement per tick
      {K_RD,3'd1,8'h00,8'h00,4'd8},
      {K_TK,3'd0,8'd5 ,8'h00,4'd8},
      {K_WR,3'd3,8'h40,8'h00,4'd2},
      {K_RD,3'd1,8'h00,8'h00,4'd8},   // R8 stays at zero
      {K_WR,3'd3,8'hE4,8'h00,4'd6},
      {K_RD,3'd1,8'h00,8'h30,4'd7},   // R7 status byte
      {K_RD,3'd1,8'h00,8'h00,4'd7},   // R7 pointer not advanced
      {K_WR,3'd3,8'h74,8'h00,4'd3},   // ch1 mode 2
      {K_WR,3'd3,8'hE4,8'h00,4'd6},
      {K_RD,3'd1,8'h00,8'h34,4'd10},  // R10 mode 2 reported
      {K_WR,3'd3,8'hB6,8'h00,4'd3},   // ch2 mode 3
      {K_WR,3'd2,8'h00,8'h00,4'd4},
      {K_WR,3'd2,8'h00,8'h00,4'd4},
      {K_WR,3'd3,8'hD8,8'h00,4'd6},   // read-back count only, ch2
      {K_RD,3'd2,8'h00,8'hFF,4'd4},   // R4 zero means 0xFFFF
      {K_RD,3'd2,8'h00,8'hFF,4'd6},   // R6 latched high byte
      {K_RD,3'd4,8'h00,8'h01,4'd12},  // R12 square wave on bit 0
      {K_WR,3'd2,8'h04,8'h00,4'd9},
      {K_WR,3'd2,8'h00,8'h00,4'd9},
      {K_RD,3'd4,8'h00,8'h01,4'd9},   // R9 count 4 > 2
      {K_TK,3'd0,8'd1 ,8'h00,4'd9},
      {K_RD,3'd4,8'h00,8'h01,4'd9},   // count 3
      {K_TK,3'd0,8'd1 ,8'h00,4'd9},
      {K_RD,3'd4,8'h00,8'h00,4'd9},   // count 2
      {K_TK,3'd0,8'd1 ,8'h00,4'd9},
      {K_RD,3'd4,8'h00,8'h00,4'd9},   // count 1
      {K_TK,3'd0,8'd1 ,8'h00,4'd9},
      {K_RD,3'd4,8'h00,8'h01,4'd9},   // reloaded to 4
      {K_WR,3'd3,8'hB0,8'h00,4'd3},   // ch2 mode 0
      {K_WR,3'd2,8'h03,8'h00,4'd4},
      {K_WR,3'd2,8'h00,8'h00,4'd4},
      {K_RD,3'd4,8'h00,8'h00,4'd12},
      {K_TK,3'd0,8'd3 ,8'h00,4'd8},
      {K_RD,3'd4,8'h00,8'h20,4'd12},  // R12 terminal count on bit 5
      {K_RD,3'd3,8'h00,8'h00,4'd13},  // R13 control read is zero
      {K_WR,3'd4,8'hFF,8'h00,4'd12},
      {K_RD,3'd4,8'h00,8'h20,4'd12},  // R12 aux write ignored
      {K_WR,3'd1,8'h07,8'h00,4'd3},   // pending low byte
      {K_WR,3'd3,8'h70,8'h00,4'd3},   // R3 sequencer reset
      {K_WR,3'd1,8'h09,8'h00,4'd3},
      {K_WR,3'd1,8'h00,8'h00,4'd3},
      {K_WR,3'd3,8'h40,8'h00,4'd2},
      {K_RD,3'd1,8'h00,8'h09,4'd3},
      {K_RD,3'd1,8'h00,8'h00,4'd3},
      {K_WR,3'd3,8'hC4,8'h00,4'd6},   // count and status, ch1
      {K_RD,3'd1,8'h00,8'h30,4'd7},
      {K_RD,3'd1,8'h00,8'h09,4'd6},
      {K_RD,3'd1,8'h00,8'h00,4'd6},
      {K_TK,3'd0,8'd2 ,8'h00,4'd5},
      {K_RD,3'd1,8'h00,8'h09,4'd5}    // R5 latch holds while counting
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rdata, exp);
   endtask

   task automatic tick(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 rdata", rdata, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         logic [24:0] v;
         v = VEC[i];
         case (v[24:23])
            K_WR: wr(v[22:20], v[19:12]);
            K_RD: rd(v[22:20], v[11:4], $sformatf("R%0d vec%0d", v[3:0], i));
            default: tick(int'(v[19:12]));
         endcase
      end

      // R11 one-shot on channel 0: reload 3, irq one cycle after third tick
      wr(3'd3, 8'h30); wr(3'd0, 8'h03); wr(3'd0, 8'h00);
      tick_en = 1'b1;
      @(negedge clk); check("R11 tick1", {7'd0, irq}, 8'h00);
      @(negedge clk); check("R11 tick2", {7'd0, irq}, 8'h00);
      @(negedge clk); check("R11 tick3", {7'd0, irq}, 8'h01);
      tick_en = 1'b0;
      @(negedge clk); check("R11 pulse end", {7'd0, irq}, 8'h00);

      // R9 R11 square wave reload 2: four ticks give two pulses
      wr(3'd3, 8'h36); wr(3'd0, 8'h02); wr(3'd0, 8'h00);
      base = irq_cnt;
      tick(4);
      @(negedge clk);
      check("R9 R11 square pulses", 8'(irq_cnt - base), 8'd2);

      // R14 load collides with expiry
      wr(3'd3, 8'h30); wr(3'd0, 8'h02); wr(3'd0, 8'h00);
      tick(1);
      wr(3'd0, 8'h05);
      base = irq_cnt;
      tick_en = 1'b1;
      wr(3'd0, 8'h00);
      tick_en = 1'b0;
      check("R14 no irq on load", {7'd0, irq}, 8'h00);
      @(negedge clk);
      check("R14 no irq count", 8'(irq_cnt - base), 8'd0);
      wr(3'd3, 8'h00);
      rd(3'd0, 8'h05, "R14 reload kept");
      rd(3'd0, 8'h00, "R14 reload kept hi");

      // R14 latch collides with tick
      tick_en = 1'b1;
      wr(3'd3, 8'h00);
      tick_en = 1'b0;
      rd(3'd0, 8'h05, "R14 latch pre-tick");
      wr(3'd3, 8'h00);
      rd(3'd0, 8'h04, "R14 post-tick count");

      finish_run();
   end

endmodule